// File: doc/BRIEF.md
# Nonvolatile Page Erase and Program Controller

This block sits between a serial-bus command layer and a byte-wide nonvolatile array that occupies the address window 0xF800 to 0xFBFF. The command layer hands it one request at a time: either program a single byte, or erase the 32-byte page that contains an address. The controller decides whether the request may proceed, runs the operation for a fixed number of clock cycles, and commits the result to the array when that time has elapsed.

The array is modelled as registers, and an erased byte reads 0xFF. A byte may be programmed only while it is still blank. An erase goes ahead only when the erase-enable input is high. While an erase runs, the controller raises `busy`, which the bus layer uses to refuse (NACK) further traffic. While a program runs, it raises both `busy` and `hold`, which the bus layer uses to stretch the serial clock until the next byte of a block write can be taken. Requests that arrive during an operation are refused and are not queued. A read port lets the command layer fetch any byte of the window at any time.

Top module: `nvpe_ctrl`

## Requirements
- R1: After reset, `busy`, `hold`, `ack`, `rej` and `err` are 0 and every byte of the window reads 0xFF on `rd_data`; a read outside the window also returns 0xFF.
- R2: A program request (`req_erase`=0) to an in-window byte that reads 0xFF is accepted: `ack` pulses for one cycle, the cycle after the request is sampled. `busy` and `hold` are then high for exactly PROG_CYC cycles, after which the byte reads `req_data`. Any in-window address may be used, including the last byte of one page followed by the first byte of the next.
- R3: An erase request (`req_erase`=1) with `erase_en`=1 is accepted with an `ack` pulse. `busy` is then high for exactly ERASE_CYC cycles, and `hold` stays 0 for the whole time. Afterwards all 32 bytes of the page selected by address bits [15:5] read 0xFF. Bits [4:0] of the request address have no effect, and bytes in other pages are unchanged.
- R4: An erase request with `erase_en`=0 is refused with a one-cycle `rej` pulse. `busy` stays 0 and the page contents are unchanged.
- R5: A program request to an in-window byte that does not read 0xFF is refused with a `rej` pulse. The byte keeps its value, `busy` stays 0, and `err` goes to 1 and stays 1 until the next reset.
- R6: Any request sampled while `busy` is 1 is refused with `rej` and never runs later. This includes a request sampled in the final busy cycle. The running operation still completes with its own result.
- R7: A request whose address lies outside 0xF800 to 0xFBFF is refused with `rej`. `busy` stays 0, `err` is unchanged and no byte changes.
- R8: `ack` and `rej` are never high in the same cycle, and `hold` is never high without `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| erase_en | input | 1 | Level that permits page erase |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_erase | input | 1 | 1 = page erase, 0 = byte program |
| req_addr | input | 16 | Target address |
| req_data | input | 8 | Byte to program |
| rd_addr | input | 16 | Read address |
| rd_data | output | 8 | Byte at `rd_addr` (combinational) |
| busy | output | 1 | Operation in progress; bus layer NACKs |
| hold | output | 1 | Program in progress; bus layer stretches the clock |
| ack | output | 1 | One-cycle pulse: request accepted |
| rej | output | 1 | One-cycle pulse: request refused |
| err | output | 1 | Sticky flag: program to a non-blank byte was attempted |

## Verification
The end of an operation can coincide with the arrival of a new request. In that cycle the array commit, the return to idle and the decision on the newcomer all happen together. The bench counts cycles from the acceptance pulse and presents a second program request so that it is sampled on exactly the edge where the first program commits. The expected result is that the first byte holds its new value and the second request is refused and leaves its byte blank. A further request during the middle of an erase checks the same no-queue rule away from that boundary.

// File: rtl/nvpe_pkg.sv
package nvpe_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] ERASED = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ERASE = 2'd1,
        ST_PROG  = 2'd2
    } nvpe_state_e;
endpackage

// File: rtl/nvpe_addr_map.sv
module nvpe_addr_map #(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'hF800,
    parameter int                SPAN   = 1024,
    parameter int                IDX_W  = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W:0] ofs;

    always_comb begin
        ofs    = {1'b0, addr} - {1'b0, BASE};
        in_win = (addr >= BASE) && (ofs < (ADDR_W+1)'(SPAN));
        idx    = ofs[IDX_W-1:0];
    end
endmodule

// File: rtl/nvpe_timer.sv
module nvpe_timer #(
    parameter int ERASE_CYC = 2000000,
    parameter int PROG_CYC  = 25000,
    parameter int CNT_W     = 21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sel_erase,
    output logic done
);
    localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = sel_erase ? ERASE_LD : PROG_LD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/nvpe_array.sv
module nvpe_array
    import nvpe_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    parameter int NUM_PAGES  = 32,
    parameter int OFS_W      = 5,
    parameter int IDX_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_we,
    input  logic              prog_we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [BYTE_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [BYTE_W-1:0] rd_b_data
);
    localparam int DEPTH  = PAGE_BYTES * NUM_PAGES;
    localparam int PAGE_W = IDX_W - OFS_W;

    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [PAGE_W-1:0] wr_page;

    assign wr_page = wr_idx[IDX_W-1:OFS_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED;
        end else if (erase_we) begin
            for (int b = 0; b < PAGE_BYTES; b++)
                mem_q[{wr_page, OFS_W'(b)}] <= ERASED;
        end else if (prog_we) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_a_data = mem_q[rd_a_idx];
    assign rd_b_data = mem_q[rd_b_idx];
endmodule

// File: rtl/nvpe_ctrl.sv
module nvpe_ctrl
    import nvpe_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] BASE       = 16'hF800,
    parameter int                PAGE_BYTES = 32,
    parameter int                NUM_PAGES  = 32,
    parameter int                ERASE_CYC  = 2000000,
    parameter int                PROG_CYC   = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_en,
    input  logic              req_valid,
    input  logic              req_erase,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              hold,
    output logic              ack,
    output logic              rej,
    output logic              err
);
    localparam int OFS_W   = $clog2(PAGE_BYTES);
    localparam int PAGE_W  = $clog2(NUM_PAGES);
    localparam int IDX_W   = OFS_W + PAGE_W;
    localparam int SPAN    = PAGE_BYTES * NUM_PAGES;
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        nvpe_state_e       st;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
        logic              err;
        logic              ack;
        logic              rej;
    } ctl_t;

    ctl_t q_d, q_q;

    logic              req_in, rd_in;
    logic [IDX_W-1:0]  req_idx, rd_idx;
    logic [BYTE_W-1:0] cur_byte, rd_raw;
    logic              tmr_start, tmr_erase, tmr_done;
    logic              mem_erase, mem_prog;

    nvpe_addr_map #(.ADDR_W(ADDR_W), .BASE(BASE), .SPAN(SPAN), .IDX_W(IDX_W)) u_req_map (
        .addr(req_addr), .in_win(req_in), .idx(req_idx)
    );

    nvpe_addr_map #(.ADDR_W(ADDR_W), .BASE(BASE), .SPAN(SPAN), .IDX_W(IDX_W)) u_rd_map (
        .addr(rd_addr), .in_win(rd_in), .idx(rd_idx)
    );

    nvpe_timer #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .sel_erase(tmr_erase), .done(tmr_done)
    );

    nvpe_array #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .erase_we(mem_erase), .prog_we(mem_prog),
        .wr_idx(q_q.idx), .wr_data(q_q.data),
        .rd_a_idx(req_idx), .rd_a_data(cur_byte),
        .rd_b_idx(rd_idx), .rd_b_data(rd_raw)
    );

    always_comb begin
        q_d       = q_q;
        q_d.ack   = 1'b0;
        q_d.rej   = 1'b0;
        tmr_start = 1'b0;
        tmr_erase = 1'b0;
        mem_erase = 1'b0;
        mem_prog  = 1'b0;
        unique case (q_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_in) begin
                        q_d.rej = 1'b1;
                    end else if (req_erase) begin
                        if (erase_en) begin
                            q_d.st    = ST_ERASE;
                            q_d.idx   = req_idx;
                            q_d.ack   = 1'b1;
                            tmr_start = 1'b1;
                            tmr_erase = 1'b1;
                        end else begin
                            q_d.rej = 1'b1;
                        end
                    end else if (cur_byte != ERASED) begin
                        q_d.rej = 1'b1;
                        q_d.err = 1'b1;
                    end else begin
                        q_d.st    = ST_PROG;
                        q_d.idx   = req_idx;
                        q_d.data  = req_data;
                        q_d.ack   = 1'b1;
                        tmr_start = 1'b1;
                    end
                end
            end
            default: begin
                if (req_valid) q_d.rej = 1'b1;
                if (tmr_done) begin
                    mem_erase = (q_q.st == ST_ERASE);
                    mem_prog  = (q_q.st == ST_PROG);
                    q_d.st    = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '{st: ST_IDLE, idx: '0, data: '0, err: 1'b0, ack: 1'b0, rej: 1'b0};
        else        q_q <= q_d;
    end

    assign rd_data = rd_in ? rd_raw : ERASED;
    assign busy    = (q_q.st != ST_IDLE);
    assign hold    = (q_q.st == ST_PROG);
    assign ack     = q_q.ack;
    assign rej     = q_q.rej;
    assign err     = q_q.err;
endmodule

// File: rtl/nvpe_ctrl_chk.sv
module nvpe_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic hold,
    input logic ack,
    input logic rej,
    input logic err
);
    // R8
    ack_rej_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && rej));

    // R8
    hold_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> busy);

    // R2
    busy_rise_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ack);

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R6
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> (rej && !ack));
endmodule

bind nvpe_ctrl nvpe_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .hold(hold), .ack(ack), .rej(rej), .err(err)
);

// File: tb/nvpe_ctrl_tb.sv
module nvpe_ctrl_tb;
    localparam int ERASE_CYC = 40;
    localparam int PROG_CYC  = 6;
    localparam int NV        = 11;

    typedef struct packed {
        logic        er;
        logic        en;
        logic [15:0] addr;
        logic [7:0]  data;
        logic        exp_ack;
        logic        exp_err;
        logic [3:0]  rq;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'hF805, 8'hA5, 1'b1, 1'b0, 4'd2},  // R2 blank byte
        '{1'b0, 1'b0, 16'hF805, 8'h3C, 1'b0, 1'b1, 4'd5},  // R5 non-blank
        '{1'b0, 1'b0, 16'hF81F, 8'h11, 1'b1, 1'b1, 4'd2},  // R2 last byte of page
        '{1'b0, 1'b0, 16'hF820, 8'h22, 1'b1, 1'b1, 4'd2},  // R2 next page
        '{1'b1, 1'b0, 16'hF80A, 8'h00, 1'b0, 1'b1, 4'd4},  // R4 erase disabled
        '{1'b1, 1'b1, 16'hF81C, 8'h00, 1'b1, 1'b1, 4'd3},  // R3 low bits ignored
        '{1'b0, 1'b0, 16'hF805, 8'h3C, 1'b1, 1'b1, 4'd2},  // R2 blank again
        '{1'b0, 1'b0, 16'hFC00, 8'h55, 1'b0, 1'b1, 4'd7},  // R7 above window
        '{1'b0, 1'b0, 16'hF7FF, 8'h55, 1'b0, 1'b1, 4'd7},  // R7 below window
        '{1'b0, 1'b0, 16'hFBFF, 8'h77, 1'b1, 1'b1, 4'd2},  // R2 top byte
        '{1'b1, 1'b1, 16'hFBE3, 8'h00, 1'b1, 1'b1, 4'd3}   // R3 last page
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        erase_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_erase = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_data = 8'h0;
    logic [15:0] rd_addr = 16'hF800;
    logic [7:0]  rd_data;
    logic        busy, hold, ack, rej, err;

    int tests = 0;
    int fails = 0;
    bit done_flag = 1'b0;
    logic [7:0] mdl [1024];

    always #4 clk = ~clk;

    nvpe_ctrl #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .erase_en(erase_en), .req_valid(req_valid),
        .req_erase(req_erase), .req_addr(req_addr), .req_data(req_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .hold(hold),
        .ack(ack), .rej(rej), .err(err)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mdl_rd(input logic [15:0] a);
        if (a < 16'hF800 || a > 16'hFBFF) return 8'hFF;
        return mdl[a - 16'hF800];
    endfunction

    task automatic read_chk(input string tag, input logic [15:0] a);
        rd_addr = a;
        #1;
        check(tag, rd_data, mdl_rd(a));
    endtask

    task automatic run_req(input logic er, input logic en, input logic [15:0] a,
                           input logic [7:0] d, output logic got_ack, output logic got_rej,
                           output int busy_n, output logic hold_any);
        @(negedge clk);
        req_valid = 1'b1; req_erase = er; erase_en = en; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        got_ack = ack; got_rej = rej;
        busy_n = 0; hold_any = 1'b0;
        while (busy) begin
            busy_n++;
            hold_any |= hold;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 1024; i++) mdl[i] = 8'hFF;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog: all requirements, got hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic ga, gr, ha;
        int bn;
        string tg;
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 hold", hold, 0);
        check("R1 ack", ack, 0);
        check("R1 rej", rej, 0);
        check("R1 err", err, 0);
        read_chk("R1 first byte", 16'hF800);
        read_chk("R1 last byte", 16'hFBFF);
        read_chk("R1 outside", 16'h1234);

        for (int v = 0; v < NV; v++) begin
            tg = $sformatf("R%0d vec%0d", VECS[v].rq, v);
            run_req(VECS[v].er, VECS[v].en, VECS[v].addr, VECS[v].data, ga, gr, bn, ha);
            check({tg, " ack"}, ga, VECS[v].exp_ack);
            check({tg, " rej"}, gr, !VECS[v].exp_ack);
            check({tg, " busy cycles"}, bn,
                  VECS[v].exp_ack ? (VECS[v].er ? ERASE_CYC : PROG_CYC) : 0);
            if (VECS[v].exp_ack) check({tg, " hold"}, ha, !VECS[v].er);
            if (VECS[v].exp_ack) begin
                if (VECS[v].er) begin
                    for (int b = 0; b < 32; b++)
                        mdl[{VECS[v].addr[9:5], 5'(b)}] = 8'hFF;
                end else begin
                    mdl[VECS[v].addr[9:0]] = VECS[v].data;
                end
            end
            check({tg, " err"}, err, VECS[v].exp_err);
            read_chk({tg, " byte"}, VECS[v].addr);
            if (VECS[v].er) begin
                for (int b = 0; b < 32; b++)
                    read_chk({tg, " page"}, {VECS[v].addr[15:5], 5'(b)});
                read_chk({tg, " neighbour"}, 16'hF820);
            end
        end

        // R6 request in the middle of an erase is refused and not queued
        @(negedge clk);
        req_valid = 1'b1; req_erase = 1'b1; erase_en = 1'b1; req_addr = 16'hF840;
        @(negedge clk);
        req_valid = 1'b0;
        check("R6 erase ack", ack, 1);
        repeat (5) @(negedge clk);
        req_valid = 1'b1; req_erase = 1'b0; req_addr = 16'hF841; req_data = 8'h5A;
        @(negedge clk);
        req_valid = 1'b0;
        check("R6 mid rej", rej, 1);
        check("R6 mid ack", ack, 0);
        while (busy) @(negedge clk);
        repeat (PROG_CYC + 2) @(negedge clk);
        read_chk("R6 not queued", 16'hF841);

        // R6 request sampled on the completion edge of a program
        req_valid = 1'b1; req_erase = 1'b0; req_addr = 16'hF842; req_data = 8'h99;
        @(negedge clk);
        req_valid = 1'b0;
        check("R6 prog ack", ack, 1);
        repeat (PROG_CYC - 1) @(negedge clk);
        check("R6 last busy cycle", busy, 1);
        req_valid = 1'b1; req_addr = 16'hF843; req_data = 8'h12;
        @(negedge clk);
        req_valid = 1'b0;
        check("R6 edge rej", rej, 1);
        check("R6 edge ack", ack, 0);
        check("R6 edge busy", busy, 0);
        mdl[16'hF842 - 16'hF800] = 8'h99;
        read_chk("R6 first committed", 16'hF842);
        read_chk("R6 second blank", 16'hF843);
        repeat (PROG_CYC + 2) @(negedge clk);
        check("R6 stays idle", busy, 0);

        // R1 second reset clears sticky error and array
        do_reset();
        @(negedge clk);
        check("R1 err after reset", err, 0);
        read_chk("R1 byte after reset", 16'hF842);

        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule